// File: doc/BRIEF.md
# Serial Boot Entry and Byte Receiver

This block decides at reset release whether the chip comes up in serial programming mode, and if it does, which transfer style the external programmer uses. Three strap pins qualify entry: chip-enable, an external-programming select and a boot-enable pin. The serial clock pin, read at the same moment, picks between a clock-synchronous link and an asynchronous link. The decision is captured once, in the first system clock after the internally synchronised reset goes inactive. After that the pins are free to move.

In clock-synchronous mode the block is the link itself. The programmer supplies the serial clock. The block takes one data bit on each rising edge of that clock, least significant bit first, and presents each 8-bit byte with a valid flag. The flag stays up until the downstream command logic takes the byte. A busy line shows whether the block can accept a byte. The same clock shifts a loaded transmit byte out on its falling edges.

In asynchronous mode the block only reports the mode. It then connects the byte interface to a separate UART through pass-through ports. Command decoding, flash access and the UART itself are outside this block.

Top module: `ser_boot_rx`

## Requirements
- R1: `boot_active` is 1 after reset release only if, at that moment, `pin_ce`=1, `pin_xprog`=0 and `pin_boot`=1. Any other combination leaves it at 0.
- R2: When `boot_active`=1, `sync_mode` is 1 if `pin_sclk` was 1 at reset release and 0 if it was 0. `sync_mode` is 0 whenever `boot_active`=0.
- R3: After the strap values are captured, later changes on the strap pins do not change `boot_active` or `sync_mode` until the next reset.
- R4: In synchronous mode the block samples `pin_sdin` on each rising edge of `pin_sclk`. The first bit sampled becomes bit 0 of the byte. After 8 bits, `rx_data` holds the byte and `rx_valid` is 1. Both stay unchanged until the cycle in which `rx_take` is 1.
- R5: In synchronous mode `pin_busy` is 0 while the block waits for a byte. It is 1 from the first rising clock edge of a byte until that byte is taken.
- R6: When `rx_take` is 1 while `rx_valid` is 1, `rx_valid` and `pin_busy` are both 0 one system clock later.
- R7: Rising edges of `pin_sclk` while a received byte is still untaken are ignored. They neither alter `rx_data` nor start a new byte.
- R8: In synchronous mode, `tx_load` with `tx_ready`=1 captures `tx_data` and drops `tx_ready`. Bit n of the byte (LSB first) appears on `pin_sdout` after the (n+1)th falling edge of `pin_sclk`. `tx_ready` returns to 1 after the eighth falling edge.
- R9: `pin_sdout` is 1 after reset and while no byte is being sent. It returns to 1 on the rising edge that follows the last bit.
- R10: In asynchronous mode, the following ports are passed straight through: `rx_data`/`rx_valid` come from `uart_rx_data`/`uart_rx_valid`, `uart_rx_take` follows `rx_take`, `uart_tx_load`/`uart_tx_data` follow `tx_load`/`tx_data`, and `tx_ready` follows `uart_tx_ready`. `pin_busy` and `pin_sdout` stay 1, and `pin_sclk` activity has no effect.
- R11: With `boot_active`=0, and while reset is held, `pin_busy`=1, `pin_sdout`=1, `rx_valid`=0, `tx_ready`=0, `uart_tx_load`=0 and `uart_rx_take`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_ce | input | 1 | Chip-enable strap |
| pin_xprog | input | 1 | External-programming strap, must be low to enter |
| pin_boot | input | 1 | Boot-enable strap |
| pin_sclk | input | 1 | Mode strap at reset, serial clock afterwards |
| pin_sdin | input | 1 | Serial receive data |
| pin_sdout | output | 1 | Serial transmit data, idle high |
| pin_busy | output | 1 | Receive handshake, low when ready |
| boot_active | output | 1 | Serial programming mode entered |
| sync_mode | output | 1 | Clock-synchronous transfer style selected |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_take | input | 1 | Downstream consumes the received byte |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Load `tx_data` for transmission |
| tx_ready | output | 1 | Transmit path can accept a byte |
| uart_tx_load | output | 1 | Async mode: load strobe to the UART |
| uart_tx_data | output | 8 | Async mode: byte to the UART |
| uart_tx_ready | input | 1 | Async mode: UART can accept a byte |
| uart_rx_data | input | 8 | Async mode: byte from the UART |
| uart_rx_valid | input | 1 | Async mode: UART byte available |
| uart_rx_take | output | 1 | Async mode: consume strobe to the UART |

## Verification
The hardest state to reach is a received byte that is still untaken while the programmer keeps clocking. In that state the receiver must hold both the byte and the busy line, and must not start counting a new byte. The bench gets there by clocking a full byte in without asserting `rx_take`. It then shifts a second, different byte through the pins. After that it checks that the first byte is intact, takes it, and confirms that a third byte lands with its bits aligned. Strap freezing is reached the same way from the ports: the bench moves the strap pins after entry and reads the mode flags back.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_ASYNC = 2'd2
  } boot_mode_e;

  function automatic boot_mode_e decode_straps(input logic ce, input logic xprog,
                                               input logic boot, input logic clk_lvl);
    boot_mode_e m;
    if (ce && !xprog && boot) m = clk_lvl ? MODE_SYNC : MODE_ASYNC;
    else                      m = MODE_OFF;
    return m;
  endfunction

endpackage

// File: rtl/sbr_rst_sync.sv
module sbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sbr_bit_sync.sv
module sbr_bit_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) stg_q[0] <= d;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) stg_q[g] <= stg_q[g-1];
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sbr_strap_latch.sv
module sbr_strap_latch
  import sbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce,
  input  logic       xprog,
  input  logic       boot,
  input  logic       clk_lvl,
  output boot_mode_e mode,
  output logic       latched
);
  boot_mode_e mode_q, mode_d;
  logic       latched_q, latched_d;

  always_comb begin
    mode_d    = mode_q;
    latched_d = latched_q;
    if (!latched_q) begin
      latched_d = 1'b1;
      mode_d    = decode_straps(ce, xprog, boot, clk_lvl);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_OFF;
      latched_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      latched_q <= latched_d;
    end
  end

  assign mode    = mode_q;
  assign latched = latched_q;

  // R3: once captured, the mode never moves until reset
  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latched_q |=> latched_q && $stable(mode_q));
endmodule

// File: rtl/sbr_sync_rx.sv
module sbr_sync_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rise,
  input  logic              sdin,
  input  logic              take,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              busy
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d, data_q, data_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              valid_q, valid_d, busy_q, busy_d;
  logic [DATA_W-1:0] sh_next;

  assign sh_next = {sdin, sh_q[DATA_W-1:1]};

  always_comb begin
    sh_d    = sh_q;
    data_d  = data_q;
    cnt_d   = cnt_q;
    valid_d = valid_q;
    busy_d  = busy_q;
    if (valid_q && take) begin
      valid_d = 1'b0;
      busy_d  = 1'b0;
    end
    if (enable && rise && !valid_q) begin
      sh_d   = sh_next;
      busy_d = 1'b1;
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        valid_d = 1'b1;
        data_d  = sh_next;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      data_q  <= data_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      busy_q  <= busy_d;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign busy  = busy_q;

  // R5: a held byte always keeps busy raised
  p_busy_while_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> busy_q);
  // R6: consumption drops busy and valid one clock later
  p_release_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && take) |=> (!busy_q && !valid_q));
  // R4 / R7: an untaken byte keeps its value whatever the clock does
  p_hold_until_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !take) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/sbr_sync_tx.sv
module sbr_sync_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rise,
  input  logic              fall,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic              sdout,
  output logic              ready
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d, out_q, out_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    out_d  = out_q;
    if (enable && fall && pend_q) begin
      out_d = sh_q[0];
      sh_d  = sh_q >> 1;
      if (cnt_q == LAST) begin
        pend_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (enable && rise && !pend_q) begin
      out_d = 1'b1;
    end
    if (enable && load && !pend_q) begin
      pend_d = 1'b1;
      sh_d   = data;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      out_q  <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      out_q  <= out_d;
    end
  end

  assign sdout = out_q;
  assign ready = !pend_q;

  // R9: an idle rising edge puts the line back high
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rise && !pend_q && !load) |=> out_q);
  // R8: during a byte the line only moves on a falling edge
  p_shift_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !fall) |=> $stable(out_q));
endmodule

// File: rtl/ser_boot_rx.sv
module ser_boot_rx
  import sbr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_ce,
  input  logic              pin_xprog,
  input  logic              pin_boot,
  input  logic              pin_sclk,
  input  logic              pin_sdin,
  output logic              pin_sdout,
  output logic              pin_busy,
  output logic              boot_active,
  output logic              sync_mode,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_take,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_ready,
  output logic              uart_tx_load,
  output logic [DATA_W-1:0] uart_tx_data,
  input  logic              uart_tx_ready,
  input  logic [DATA_W-1:0] uart_rx_data,
  input  logic              uart_rx_valid,
  output logic              uart_rx_take
);
  localparam int NPIN = 5;

  logic            rst_s_n;
  logic [NPIN-1:0] pins_s;
  logic            ce_s, xprog_s, boot_s, sclk_s, sdin_s;
  logic            sclk_d_q;
  logic            rise, fall;
  boot_mode_e      mode;
  logic            latched;
  logic            sync_act, async_act;

  logic [DATA_W-1:0] srx_data;
  logic              srx_valid, srx_busy, stx_sdout, stx_ready;

  sbr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  sbr_bit_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_pins (
    .clk(clk),
    .d  ({pin_ce, pin_xprog, pin_boot, pin_sclk, pin_sdin}),
    .q  (pins_s)
  );
  assign {ce_s, xprog_s, boot_s, sclk_s, sdin_s} = pins_s;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) sclk_d_q <= 1'b0;
    else          sclk_d_q <= sclk_s;
  end
  assign rise = sclk_s && !sclk_d_q;
  assign fall = !sclk_s && sclk_d_q;

  sbr_strap_latch u_strap (
    .clk(clk), .rst_n(rst_s_n), .ce(ce_s), .xprog(xprog_s), .boot(boot_s),
    .clk_lvl(sclk_s), .mode(mode), .latched(latched)
  );

  assign sync_act  = (mode == MODE_SYNC);
  assign async_act = (mode == MODE_ASYNC);

  sbr_sync_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_s_n), .enable(sync_act), .rise(rise), .sdin(sdin_s),
    .take(rx_take && sync_act), .data(srx_data), .valid(srx_valid), .busy(srx_busy)
  );

  sbr_sync_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_s_n), .enable(sync_act), .rise(rise), .fall(fall),
    .load(tx_load), .data(tx_data), .sdout(stx_sdout), .ready(stx_ready)
  );

  always_comb begin
    boot_active  = (mode != MODE_OFF);
    sync_mode    = sync_act;
    pin_busy     = 1'b1;
    pin_sdout    = 1'b1;
    rx_data      = '0;
    rx_valid     = 1'b0;
    tx_ready     = 1'b0;
    uart_tx_load = 1'b0;
    uart_tx_data = '0;
    uart_rx_take = 1'b0;
    if (sync_act) begin
      pin_busy  = srx_busy;
      pin_sdout = stx_sdout;
      rx_data   = srx_data;
      rx_valid  = srx_valid;
      tx_ready  = stx_ready;
    end else if (async_act) begin
      rx_data      = uart_rx_data;
      rx_valid     = uart_rx_valid;
      uart_rx_take = rx_take;
      uart_tx_load = tx_load;
      uart_tx_data = tx_data;
      tx_ready     = uart_tx_ready;
    end
  end

  // R11: before the straps are captured the block stays silent
  p_quiet_before_latch_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !latched |-> (!boot_active && !rx_valid && !uart_tx_load));
  // R10: the synchronous receiver never starts a byte outside synchronous mode
  p_async_no_busy_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !sync_act |=> !srx_busy);
endmodule

// File: tb/sim_ser_boot_rx.sv
module sim_ser_boot_rx;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;
  localparam int NVEC  = 4;
  // {rx byte, tx byte}
  localparam logic [15:0] VEC [NVEC] = '{16'hA53C, 16'h0180, 16'hFF00, 16'h5AC3};

  logic clk = 1'b0;
  logic rst_n, pin_ce, pin_xprog, pin_boot, pin_sclk, pin_sdin;
  logic pin_sdout, pin_busy, boot_active, sync_mode;
  logic [7:0] rx_data, tx_data, uart_tx_data, uart_rx_data;
  logic rx_valid, rx_take, tx_load, tx_ready, uart_tx_load, uart_tx_ready;
  logic uart_rx_valid, uart_rx_take;

  int n_chk = 0;
  int n_fail = 0;
  logic busy_mid;
  logic [7:0] got_tx;

  always #(CLK_P/2) clk = ~clk;

  ser_boot_rx u0 (
    .clk(clk), .rst_n(rst_n), .pin_ce(pin_ce), .pin_xprog(pin_xprog), .pin_boot(pin_boot),
    .pin_sclk(pin_sclk), .pin_sdin(pin_sdin), .pin_sdout(pin_sdout), .pin_busy(pin_busy),
    .boot_active(boot_active), .sync_mode(sync_mode), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_take(rx_take), .tx_data(tx_data), .tx_load(tx_load), .tx_ready(tx_ready),
    .uart_tx_load(uart_tx_load), .uart_tx_data(uart_tx_data), .uart_tx_ready(uart_tx_ready),
    .uart_rx_data(uart_rx_data), .uart_rx_valid(uart_rx_valid), .uart_rx_take(uart_rx_take)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic ce, input logic xp, input logic bt, input logic sc);
    pin_ce = ce; pin_xprog = xp; pin_boot = bt; pin_sclk = sc;
    rst_n = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic xfer(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      pin_sclk = 1'b0;
      pin_sdin = b[i];
      wait_clk(HALF);
      got_tx[i] = pin_sdout;
      pin_sclk = 1'b1;
      wait_clk(HALF);
      if (i == 0) busy_mid = pin_busy;
    end
  endtask

  task automatic take_byte();
    rx_take = 1'b1;
    wait_clk(1);
    rx_take = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_ce = 1'b1; pin_xprog = 1'b0; pin_boot = 1'b1; pin_sclk = 1'b1;
    pin_sdin = 1'b0; rx_take = 1'b0; tx_data = '0; tx_load = 1'b0;
    uart_tx_ready = 1'b0; uart_rx_data = '0; uart_rx_valid = 1'b0;
    wait_clk(3);
    // R11: state while reset is held
    chk("R11 reset boot_active", boot_active, 0);
    chk("R11 reset busy", pin_busy, 1);
    chk("R11 reset sdout", pin_sdout, 1);
    chk("R11 reset rx_valid", rx_valid, 0);

    do_reset(1, 0, 1, 1);
    chk("R1 entry", boot_active, 1);
    chk("R2 sync select", sync_mode, 1);
    chk("R5 idle busy low", pin_busy, 0);
    chk("R9 idle sdout", pin_sdout, 1);

    for (int v = 0; v < NVEC; v++) begin
      chk("R8 ready before load", tx_ready, 1);
      tx_data = VEC[v][7:0]; tx_load = 1'b1;
      wait_clk(1);
      tx_load = 1'b0;
      chk("R8 ready drops", tx_ready, 0);
      xfer(VEC[v][15:8]);
      chk("R4 rx byte", rx_data, VEC[v][15:8]);
      chk("R4 rx valid", rx_valid, 1);
      chk("R5 busy on first edge", busy_mid, 1);
      chk("R5 busy held", pin_busy, 1);
      chk("R8 tx bits", got_tx, VEC[v][7:0]);
      chk("R8 ready after byte", tx_ready, 1);
      chk("R9 sdout idle after byte", pin_sdout, 1);
      take_byte();
      chk("R6 busy low after take", pin_busy, 0);
      chk("R6 valid low after take", rx_valid, 0);
    end

    // R7: clocking while a byte is untaken
    xfer(8'h11);
    chk("R7 first byte", rx_data, 8'h11);
    xfer(8'hEE);
    chk("R7 byte kept", rx_data, 8'h11);
    chk("R7 valid kept", rx_valid, 1);
    chk("R7 busy kept", pin_busy, 1);
    chk("R9 sdout unloaded", pin_sdout, 1);
    take_byte();
    xfer(8'h77);
    chk("R7 next byte aligned", rx_data, 8'h77);
    take_byte();

    // R3: moving straps after entry
    pin_ce = 1'b0; pin_xprog = 1'b1; pin_boot = 1'b0;
    wait_clk(10);
    chk("R3 active frozen", boot_active, 1);
    chk("R3 sync frozen", sync_mode, 1);

    // R1 / R11: failed entry combinations
    do_reset(0, 0, 1, 1);
    chk("R1 ce low", boot_active, 0);
    chk("R2 sync_mode off", sync_mode, 0);
    do_reset(1, 1, 1, 1);
    chk("R1 xprog high", boot_active, 0);
    do_reset(1, 0, 0, 1);
    chk("R1 boot low", boot_active, 0);
    uart_rx_valid = 1'b1; tx_load = 1'b1; rx_take = 1'b1; uart_tx_ready = 1'b1;
    #1;
    chk("R11 off rx_valid", rx_valid, 0);
    chk("R11 off uart_tx_load", uart_tx_load, 0);
    chk("R11 off uart_rx_take", uart_rx_take, 0);
    chk("R11 off tx_ready", tx_ready, 0);
    chk("R11 off busy", pin_busy, 1);
    chk("R11 off sdout", pin_sdout, 1);
    uart_rx_valid = 1'b0; tx_load = 1'b0; rx_take = 1'b0; uart_tx_ready = 1'b0;

    // R2 / R10: asynchronous mode
    do_reset(1, 0, 1, 0);
    chk("R2 async active", boot_active, 1);
    chk("R2 async select", sync_mode, 0);
    uart_rx_data = 8'h42; uart_rx_valid = 1'b1; uart_tx_ready = 1'b1;
    tx_data = 8'h9D; tx_load = 1'b1; rx_take = 1'b1;
    #1;
    chk("R10 rx_data", rx_data, 8'h42);
    chk("R10 rx_valid", rx_valid, 1);
    chk("R10 uart_rx_take", uart_rx_take, 1);
    chk("R10 uart_tx_load", uart_tx_load, 1);
    chk("R10 uart_tx_data", uart_tx_data, 8'h9D);
    chk("R10 tx_ready", tx_ready, 1);
    uart_tx_ready = 1'b0; tx_load = 1'b0; rx_take = 1'b0; uart_rx_valid = 1'b0;
    #1;
    chk("R10 tx_ready follows", tx_ready, 0);
    chk("R10 uart_tx_load off", uart_tx_load, 0);
    xfer(8'h00);
    chk("R10 busy high", pin_busy, 1);
    chk("R10 sdout high", pin_sdout, 1);
    chk("R10 no sync byte", rx_valid, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule